// File: doc/BRIEF.md
# Early Instruction-Line Request Issuer

In a multithreaded instruction fetch stage, each thread's fetch work for a cycle can end in two ways. The thread may stop because it ran out of bandwidth, which means it fetched fewer instructions than the fetch width allows. It may also stop because it is stalled. When a thread stops for bandwidth reasons, the cache line it will need next can be requested right away, so that the next cache access overlaps the current one. This block makes that decision for every thread at the close of each fetch cycle and drives a single line-request port.

The fetch stage pulses `cycle_end` once it has processed all threads, and holds the per-thread inputs stable in that cycle. For each thread the block checks whether the thread is eligible for an early request. It then forms the target line address from the PC and the fetch offset. It drops the request if the PC is a microcode-ROM micro-PC, or if the thread's held line buffer already covers the target block. Each surviving request sets a per-thread pending bit. Pending threads are then offered on the request port one at a time, lowest thread ID first, and each bit stays set until the port accepts it.

Top module: `lpf_issuer`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `req_valid` is low and no thread is pending.
- R2: In a cycle with `cycle_end` high, thread t is eligible only if `thr_fetched[t] < fetch_width` (unsigned) and `thr_state[t]` is none of the stall codes 4 (waiting for cache response), 5 (waiting for translation) or 6 (waiting for cache retry). The other codes 0..3 and 7 do not block eligibility.
- R3: An eligible thread whose `thr_rom_upc[t]` is high gets no request.
- R4: An eligible thread gets no request when `lbuf_valid[t]` is high and `lbuf_base[t]` equals its aligned target. A tag that differs from the target, or a clear valid bit, does not block the request.
- R5: The target address is `((thr_pc[t] + thr_off[t]) mod 2^ADDR_W) & PC_MASK`, with the low log2(BLOCK_BYTES) bits then cleared. The default mask clears address bit 31 and the default block is 64 bytes.
- R6: When one or more threads are pending, `req_valid` is high, and `req_tid` and `req_addr` show the lowest-numbered pending thread and its stored target.
- R7: A pending request remains pending, and `req_valid` stays high, until a cycle in which `req_valid` and `req_ready` are both high. That cycle clears the presented thread's bit from the next cycle on.
- R8: A request is visible on the port in the cycle after the `cycle_end` that produced it. If a thread gets a new request while it is still pending, its stored address is replaced, and this replacement takes priority over an acceptance in the same cycle.
- R9: When `cycle_end` is low, the per-thread inputs have no effect: no thread becomes pending and no stored address changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_end | input | 1 | Strobe: all threads processed this fetch cycle |
| thr_pc | input | NTHREADS x ADDR_W | Per-thread instruction address of the next PC |
| thr_off | input | NTHREADS x ADDR_W | Per-thread current fetch offset |
| thr_state | input | NTHREADS x 3 | Per-thread fetch state code |
| thr_fetched | input | NTHREADS x CNT_W | Instructions the thread fetched this cycle |
| fetch_width | input | CNT_W | Fetch width limit |
| thr_rom_upc | input | NTHREADS | Next PC is a microcode-ROM micro-PC |
| lbuf_valid | input | NTHREADS | Thread's line buffer holds valid data |
| lbuf_base | input | NTHREADS x ADDR_W | Block address held in the thread's line buffer |
| req_valid | output | 1 | Line request present |
| req_addr | output | ADDR_W | Block-aligned request address |
| req_tid | output | TID_W | Thread ID of the request |
| req_ready | input | 1 | Request accepted this cycle when high with req_valid |

## Verification
Every result of this block is due exactly one rising edge after its cause. A `cycle_end` cycle shows its new pending requests, and an accepting cycle shows the cleared bit, on the next edge, and both feed through only the pending and address registers. The bench drives inputs on the falling edge and advances its reference model by one edge for each cycle. It compares valid, thread ID and address at the following falling edge, which is one register stage after the stimulus. Thread ID and address are compared only while valid is high.

// File: rtl/lpf_pkg.sv
package lpf_pkg;

  typedef enum logic [2:0] {
    FS_RUN        = 3'd0,
    FS_IDLE       = 3'd1,
    FS_SQUASH     = 3'd2,
    FS_BLOCKED    = 3'd3,
    FS_WAIT_RESP  = 3'd4,
    FS_WAIT_XLATE = 3'd5,
    FS_WAIT_RETRY = 3'd6,
    FS_TRAP       = 3'd7
  } fetch_state_e;

  // A thread in one of these states is waiting on memory, so it gets no early request.
  function automatic logic is_mem_stall(input logic [2:0] code);
    fetch_state_e st;
    st = fetch_state_e'(code);
    return (st == FS_WAIT_RESP) || (st == FS_WAIT_XLATE) || (st == FS_WAIT_RETRY);
  endfunction

endpackage

// File: rtl/lpf_target_calc.sv
module lpf_target_calc
  import lpf_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int BLOCK_BYTES = 64,
  parameter logic [AW-1:0] PC_MASK = '1
) (
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] off,
  input  logic [2:0]    state,
  input  logic [CW-1:0] fetched,
  input  logic [CW-1:0] width,
  input  logic          rom_upc,
  input  logic          lb_valid,
  input  logic [AW-1:0] lb_base,
  output logic          flag,
  output logic          lb_hit,
  output logic          cand,
  output logic [AW-1:0] target
);

  localparam int BLK_LOG = $clog2(BLOCK_BYTES);
  localparam logic [AW-1:0] BLK_MASK = AW'(BLOCK_BYTES - 1);

  // Masked sum, then rounded down to the start of its block.
  function automatic logic [AW-1:0] line_base(input logic [AW-1:0] p, input logic [AW-1:0] o);
    logic [AW-1:0] sum;
    sum = (p + o) & PC_MASK;
    return sum & ~BLK_MASK;
  endfunction

  // Bandwidth-limited stop, as opposed to a memory stall.
  function automatic logic bw_limited(input logic [CW-1:0] n, input logic [CW-1:0] w,
                                      input logic [2:0] s);
    return (n < w) && !is_mem_stall(s);
  endfunction

  always_comb begin
    target = line_base(pc, off);
    flag   = bw_limited(fetched, width, state);
    lb_hit = lb_valid && (lb_base == target);
    cand   = flag && !rom_upc && !lb_hit;
  end

  initial begin
    AST_BLOCK_POW2: assert ((1 << BLK_LOG) == BLOCK_BYTES); // R5
  end

endmodule

// File: rtl/lpf_slot_bank.sv
module lpf_slot_bank #(
  parameter int NT = 4,
  parameter int AW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [NT-1:0]      cand,
  input  logic [NT-1:0][AW-1:0] tgt,
  input  logic [NT-1:0]      clr,
  output logic [NT-1:0]      pend,
  output logic [NT-1:0][AW-1:0] addr
);

  logic [NT-1:0] set_vec;
  logic [NT-1:0] pend_d;

  assign set_vec = load ? cand : '0;
  // Clear first, set afterwards, so a fresh request wins over an acceptance.
  assign pend_d  = (pend & ~clr) | set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_d;
  end

  for (genvar t = 0; t < NT; t++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          addr[t] <= '0;
      else if (set_vec[t]) addr[t] <= tgt[t];
    end

    AST_HOLD_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      pend[t] && !clr[t] |=> pend[t]); // R7

    AST_NO_SET_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !load && !pend[t] |=> !pend[t]); // R9

    AST_ADDR_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(addr[t])); // R9
  end

endmodule

// File: rtl/lpf_pick.sv
module lpf_pick #(
  parameter int NT = 4,
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] pend,
  output logic [NT-1:0] grant,
  output logic [TW-1:0] tid,
  output logic          any
);

  // Walk downward so that the lowest set bit is assigned last and wins.
  always_comb begin
    grant = '0;
    tid   = '0;
    for (int i = NT - 1; i >= 0; i--) begin
      if (pend[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        tid      = TW'(i);
      end
    end
  end

  assign any = |pend;

  AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> $countones(grant) == 1); // R6

  AST_GRANT_IN_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~pend) == '0); // R6

  AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((grant - 1'b1) & pend) == '0); // R6

endmodule

// File: rtl/lpf_issuer.sv
module lpf_issuer
  import lpf_pkg::*;
#(
  parameter int NTHREADS = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W = 4,
  parameter int BLOCK_BYTES = 64,
  parameter logic [ADDR_W-1:0] PC_MASK = 32'h7FFF_FFFF,
  parameter int TID_W = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cycle_end,
  input  logic [NTHREADS-1:0][ADDR_W-1:0]  thr_pc,
  input  logic [NTHREADS-1:0][ADDR_W-1:0]  thr_off,
  input  logic [NTHREADS-1:0][2:0]         thr_state,
  input  logic [NTHREADS-1:0][CNT_W-1:0]   thr_fetched,
  input  logic [CNT_W-1:0]                 fetch_width,
  input  logic [NTHREADS-1:0]              thr_rom_upc,
  input  logic [NTHREADS-1:0]              lbuf_valid,
  input  logic [NTHREADS-1:0][ADDR_W-1:0]  lbuf_base,
  output logic                             req_valid,
  output logic [ADDR_W-1:0]                req_addr,
  output logic [TID_W-1:0]                 req_tid,
  input  logic                             req_ready
);

  localparam logic [ADDR_W-1:0] BLK_MASK = ADDR_W'(BLOCK_BYTES - 1);

  // Named internal events for the assertions.
  logic [NTHREADS-1:0]             elig_flag;
  logic [NTHREADS-1:0]             buf_hit;
  logic [NTHREADS-1:0]             cand;
  logic [NTHREADS-1:0][ADDR_W-1:0] tgt;
  logic [NTHREADS-1:0]             pend;
  logic [NTHREADS-1:0][ADDR_W-1:0] slot_addr;
  logic [NTHREADS-1:0]             grant;
  logic [NTHREADS-1:0]             accept_vec;
  logic                            any_pend;
  logic [TID_W-1:0]                pick_tid;
  logic                            accept;

  for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
    lpf_target_calc #(
      .AW(ADDR_W), .CW(CNT_W), .BLOCK_BYTES(BLOCK_BYTES), .PC_MASK(PC_MASK)
    ) u_calc (
      .pc       (thr_pc[t]),
      .off      (thr_off[t]),
      .state    (thr_state[t]),
      .fetched  (thr_fetched[t]),
      .width    (fetch_width),
      .rom_upc  (thr_rom_upc[t]),
      .lb_valid (lbuf_valid[t]),
      .lb_base  (lbuf_base[t]),
      .flag     (elig_flag[t]),
      .lb_hit   (buf_hit[t]),
      .cand     (cand[t]),
      .target   (tgt[t])
    );

    AST_STALL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_end && is_mem_stall(thr_state[t]) && !pend[t] |=> !pend[t]); // R2

    AST_FULL_WIDTH_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_end && (thr_fetched[t] >= fetch_width) && !pend[t] |=> !pend[t]); // R2

    AST_ROM_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_end && thr_rom_upc[t] && !pend[t] |=> !pend[t]); // R3

    AST_HIT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_end && buf_hit[t] && !pend[t] |=> !pend[t]); // R4

    AST_NEW_REQ_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_end && elig_flag[t] && !thr_rom_upc[t] && !buf_hit[t]
      |=> pend[t] && slot_addr[t] == $past(tgt[t])); // R8
  end

  lpf_pick #(.NT(NTHREADS), .TW(TID_W)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend),
    .grant (grant),
    .tid   (pick_tid),
    .any   (any_pend)
  );

  assign accept     = any_pend && req_ready;
  assign accept_vec = accept ? grant : '0;

  lpf_slot_bank #(.NT(NTHREADS), .AW(ADDR_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cycle_end),
    .cand  (cand),
    .tgt   (tgt),
    .clr   (accept_vec),
    .pend  (pend),
    .addr  (slot_addr)
  );

  assign req_valid = any_pend;
  assign req_tid   = pick_tid;
  assign req_addr  = slot_addr[pick_tid];

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid); // R7

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr & BLK_MASK) == '0); // R5

  AST_ADDR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr & ~PC_MASK) == '0); // R5

  AST_ACCEPT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !cycle_end |=> !pend[$past(pick_tid)]); // R7

endmodule

// File: tb/sim_lpf_issuer.sv
`timescale 1ns/1ps
module sim_lpf_issuer;

  localparam int NT = 4;
  localparam int AW = 32;
  localparam int CW = 4;
  localparam int BB = 64;
  localparam logic [31:0] MASK = 32'h7FFF_FFFF;

  logic clk = 1'b0;
  logic rst_n;
  logic cycle_end;
  logic [NT-1:0][AW-1:0] thr_pc, thr_off, lbuf_base;
  logic [NT-1:0][2:0]    thr_state;
  logic [NT-1:0][CW-1:0] thr_fetched;
  logic [CW-1:0]         fetch_width;
  logic [NT-1:0]         thr_rom_upc, lbuf_valid;
  logic                  req_valid, req_ready;
  logic [AW-1:0]         req_addr;
  logic [1:0]            req_tid;

  always #4 clk = ~clk;

  lpf_issuer u0 (
    .clk(clk), .rst_n(rst_n), .cycle_end(cycle_end),
    .thr_pc(thr_pc), .thr_off(thr_off), .thr_state(thr_state),
    .thr_fetched(thr_fetched), .fetch_width(fetch_width),
    .thr_rom_upc(thr_rom_upc), .lbuf_valid(lbuf_valid), .lbuf_base(lbuf_base),
    .req_valid(req_valid), .req_addr(req_addr), .req_tid(req_tid),
    .req_ready(req_ready)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // Reference state: a pending set plus one address per thread.
  bit          m_pend [NT];
  logic [31:0] m_addr [NT];

  function automatic logic [31:0] ref_target(int t);
    longint unsigned s;
    s = (longint'(thr_pc[t]) + longint'(thr_off[t])) % 64'h1_0000_0000;
    s = s & longint'(MASK);
    return 32'(s - (s % BB));
  endfunction

  function automatic bit ref_wants(int t);
    int st;
    st = int'(thr_state[t]);
    if (!(int'(thr_fetched[t]) < int'(fetch_width))) return 0;
    if (st == 4 || st == 5 || st == 6) return 0;
    if (thr_rom_upc[t]) return 0;
    if (lbuf_valid[t] && lbuf_base[t] == ref_target(t)) return 0;
    return 1;
  endfunction

  function automatic int ref_lowest();
    for (int t = 0; t < NT; t++) if (m_pend[t]) return t;
    return -1;
  endfunction

  task automatic compare(string tag);
    int lo;
    bit ev;
    lo = ref_lowest();
    ev = (lo >= 0);
    vectors++;
    if (req_valid !== ev) begin
      miscompares++;
      $display("FAIL %s: req_valid=%0b expected %0b", tag, req_valid, ev);
    end else if (ev && (int'(req_tid) != lo || req_addr !== m_addr[lo])) begin
      miscompares++;
      $display("FAIL %s: tid=%0d addr=%h expected tid=%0d addr=%h",
               tag, req_tid, req_addr, lo, m_addr[lo]);
    end
  endtask

  // Advance the model over one rising edge with the inputs as driven, then compare.
  task automatic step(string tag);
    int lo;
    bit wants [NT];
    logic [31:0] tg [NT];
    lo = ref_lowest();
    for (int t = 0; t < NT; t++) begin
      wants[t] = ref_wants(t);
      tg[t] = ref_target(t);
    end
    if (lo >= 0 && req_ready) m_pend[lo] = 0;
    if (cycle_end)
      for (int t = 0; t < NT; t++)
        if (wants[t]) begin
          m_pend[t] = 1;
          m_addr[t] = tg[t];
        end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic quiet();
    cycle_end = 0; req_ready = 0; fetch_width = 4'd8;
    for (int t = 0; t < NT; t++) begin
      thr_pc[t] = 32'h1000 * (t + 1); thr_off[t] = 0; thr_state[t] = 3'd0;
      thr_fetched[t] = 4'd8; thr_rom_upc[t] = 0; lbuf_valid[t] = 0; lbuf_base[t] = 0;
    end
  endtask

  task automatic drain(string tag);
    quiet();
    req_ready = 1;
    for (int i = 0; i < NT + 1; i++) step(tag);
    req_ready = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NT; t++) begin m_pend[t] = 0; m_addr[t] = 0; end
    quiet();
    rst_n = 0;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1;
    step("R1 after release");

    // R9: eligible inputs without the strobe change nothing.
    quiet();
    for (int t = 0; t < NT; t++) thr_fetched[t] = 4'd1;
    step("R9 no strobe");
    step("R9 no strobe");

    // R2: boundary count and stall codes.
    quiet(); cycle_end = 1;
    thr_fetched[0] = 4'd7;                      // one below width: issues
    thr_fetched[1] = 4'd8;                      // at width: no
    thr_fetched[2] = 4'd2; thr_state[2] = 3'd4; // waiting response
    thr_fetched[3] = 4'd2; thr_state[3] = 3'd6; // waiting retry
    step("R2 eligibility");
    quiet(); thr_fetched[1] = 4'd0; thr_state[1] = 3'd5; cycle_end = 1;
    step("R2 translation stall");
    quiet(); thr_fetched[3] = 4'd0; thr_state[3] = 3'd7; cycle_end = 1;
    step("R2 non-stall code 7");
    drain("R2 drain");

    // R3: microcode ROM.
    quiet(); cycle_end = 1;
    thr_fetched[0] = 0; thr_rom_upc[0] = 1;
    thr_fetched[2] = 0;
    step("R3 rom suppress");
    drain("R3 drain");

    // R4: line buffer hit, miss by one block, valid clear.
    quiet(); cycle_end = 1;
    for (int t = 0; t < 3; t++) begin thr_fetched[t] = 0; thr_pc[t] = 32'h0000_2010; end
    lbuf_valid[0] = 1; lbuf_base[0] = 32'h0000_2000;
    lbuf_valid[1] = 1; lbuf_base[1] = 32'h0000_2040;
    lbuf_valid[2] = 0; lbuf_base[2] = 32'h0000_2000;
    step("R4 buffer hit");
    drain("R4 drain");

    // R5: carry into the block, wrap-around and mask of bit 31.
    quiet(); cycle_end = 1;
    thr_fetched[0] = 0; thr_pc[0] = 32'h0000_003C; thr_off[0] = 32'h8;
    thr_fetched[1] = 0; thr_pc[1] = 32'hFFFF_FFF0; thr_off[1] = 32'h20;
    thr_fetched[2] = 0; thr_pc[2] = 32'h8000_1234; thr_off[2] = 32'h0;
    step("R5 target math");
    req_ready = 1; cycle_end = 0;
    step("R5 target math");
    step("R5 target math");
    drain("R5 drain");

    // R6 and R7: all four pending, hold with ready low, then ascending order.
    quiet(); cycle_end = 1;
    for (int t = 0; t < NT; t++) thr_fetched[t] = 4'd3;
    step("R6 all flagged");
    cycle_end = 0;
    for (int i = 0; i < 3; i++) step("R7 hold without ready");
    req_ready = 1;
    for (int i = 0; i < NT + 1; i++) step("R6 ascending order");

    // R8: replacement while pending, and replace colliding with accept.
    quiet(); cycle_end = 1; thr_fetched[1] = 0;
    step("R8 first request");
    thr_pc[1] = 32'h0000_5000;
    step("R8 replace pending");
    req_ready = 1; thr_pc[1] = 32'h0000_6000;
    step("R8 replace over accept");
    cycle_end = 0;
    step("R8 after accept");
    drain("R8 drain");

    // Mixed traffic against the model.
    for (int i = 0; i < 3000; i++) begin
      cycle_end = ($urandom % 5) < 3;
      req_ready = $urandom % 2;
      fetch_width = 4'($urandom % 9);
      for (int t = 0; t < NT; t++) begin
        thr_pc[t] = ($urandom % 4 == 0) ? 32'hFFFF_FF00 + ($urandom % 256) : $urandom;
        thr_off[t] = $urandom % 128;
        thr_state[t] = 3'($urandom % 8);
        thr_fetched[t] = 4'($urandom % 9);
        thr_rom_upc[t] = ($urandom % 8) == 0;
        lbuf_valid[t] = $urandom % 2;
        lbuf_base[t] = ($urandom % 2) ? ref_target(t) : ref_target(t) ^ 32'h40;
      end
      step("R6 R7 R8 mixed");
    end
    drain("R7 final drain");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule